// File: doc/BRIEF.md
# Configurable-Length Serial Converter Port

This block is the digital side of a pipelined successive-approximation converter's serial port. While chip-select is low, an external I/O clock shifts an 8-bit command in on `din` and shifts the result of the previous conversion out on `dout`, one bit per I/O clock. Each command carries four things. The high four bits are the channel address. Two bits set how many clocks the current transfer has. One bit sets the output bit order for the next transfer. The lowest bit is received and ignored. The command takes effect at the end of the transfer that carries it. At that point the sample window on the addressed channel closes, a conversion starts, and end-of-conversion drops until the result is ready.

All port inputs are resampled on the system clock `clk` and their edges are found there, so the I/O clock must be much slower than `clk`. A stub takes the place of the analog conversion. It returns a value derived from the channel address after a fixed number of system clocks.

Top module: `sar_serial_port`

## Requirements
- R1: Command bits 3:2 (counting bit 7 as the first received) set the transfer length: 01 gives 8 clocks, 11 gives 16 clocks, and 00 or 10 give 12 clocks. The length applies to the transfer that carries it. At the last falling I/O edge of that transfer the sample window closes, `convert` rises and `eoc` falls.
- R2: In MSB-first order, output bit k (k = 0 is presented when chip-select falls; each later bit follows a falling I/O edge) is result bit 11-k.
- R3: In 16-clock transfers the 12 result bits are followed by four 0 bits in the low positions. Those zeros are the last four bits in MSB-first order and the first four bits in LSB-first order.
- R4: In 8-clock transfers only result bits 11:4 are sent. In LSB-first order the bit sequence runs 4..11.
- R5: Command bit 1 selects the order: 0 for MSB first, 1 for LSB first. It affects the next transfer only.
- R6: `sample` rises at the 4th falling I/O edge and stays high until the last falling edge of the transfer.
- R7: `convert` stays high and `eoc` stays low for CONV_CYCLES system clocks. Then `eoc` returns high and the new result is held for output.
- R8: Each transfer outputs the result of the conversion started at the end of the previous transfer. The stub result for channel a is (a*273+245) mod 4096. `chan` shows the address taken from command bits 7:4.
- R9: The new length takes effect at the 6th rising I/O edge. Output bits 0..5 follow the previous transfer's length and bits 6 onward follow the new one, so a length change in LSB-first order corrupts one result.
- R10: After reset, `dout`=0, `eoc`=1, `sample`=0, `convert`=0 and `chan`=0. The held result is 0, the order is MSB first and the previous length counts as 12.
- R11: Raising chip-select before the last falling edge aborts the transfer. No conversion starts, and the held result, order and length stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_clk | input | 1 | Serial I/O clock |
| cs_n | input | 1 | Active-low chip-select |
| din | input | 1 | Serial command input |
| dout | output | 1 | Serial result output |
| eoc | output | 1 | End of conversion, high when idle |
| sample | output | 1 | Sample window active |
| convert | output | 1 | Conversion in progress |
| chan | output | ADDR_W | Selected channel address |

## Verification
The bench changes length between consecutive transfers while LSB-first order is active. A design that applied the new length from the first bit, or never applied it, would emit a differently shifted word than the 6th-edge rule predicts. It writes an order bit and checks that the transfer carrying it still uses the old order. A design that switched immediately would mirror that word. It also checks 16-clock padding and 8-clock truncation in both orders, the sample window edges at the 4th and last falling edge, and an aborted transfer. A design that started a conversion or took the aborted command's settings on early chip-select release would show a falling `eoc` or a changed next word.

// File: rtl/sar_sport_pkg.sv
package sar_sport_pkg;

   typedef enum logic [1:0] {
      LEN_MID   = 2'd0,
      LEN_SHORT = 2'd1,
      LEN_LONG  = 2'd2
   } wlen_e;

   function automatic wlen_e decode_len(input logic [1:0] fld);
      case (fld)
         2'b01:   return LEN_SHORT;
         2'b11:   return LEN_LONG;
         default: return LEN_MID;
      endcase
   endfunction

endpackage

// File: rtl/sar_sport_sync.sv
module sar_sport_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic io_clk,
   input  logic cs_n,
   input  logic din,
   output logic rise,
   output logic fall,
   output logic sel_start,
   output logic sel_end,
   output logic din_s
);
   localparam logic [2:0] IDLE_LVL = 3'b010;

   logic [2:0] raw;
   logic [2:0] s;
   logic [1:0] prev;

   assign raw = {io_clk, cs_n, din};

   generate
      if (STAGES < 0) begin : g_bad_stages
         $error("STAGES must not be negative");
      end
      if (STAGES == 0) begin : g_direct
         assign s = raw;
      end else begin : g_chain
         logic [2:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= IDLE_LVL;
            end else begin
               st[0] <= raw;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign s = st[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= IDLE_LVL[2:1];
      else        prev <= s[2:1];
   end

   assign rise      =  s[2] & ~prev[1] & ~s[1];
   assign fall      = ~s[2] &  prev[1] & ~s[1];
   assign sel_start = ~s[1] &  prev[0];
   assign sel_end   =  s[1] & ~prev[0];
   assign din_s     =  s[0];
endmodule

// File: rtl/sar_sport_frame.sv
module sar_sport_frame
   import sar_sport_pkg::*;
#(
   parameter int RES_W   = 12,
   parameter int SHORT_W = 8,
   parameter int LONG_W  = 16,
   parameter int CMD_W   = 8,
   parameter int ADDR_W  = 4,
   parameter int KW      = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise,
   input  logic              fall,
   input  logic              sel_start,
   input  logic              sel_end,
   input  logic              din_s,
   output logic              step,
   output logic [KW-1:0]     step_idx,
   output wlen_e             step_len,
   output logic              order_lsb,
   output logic              smp_begin,
   output logic              frame_done,
   output logic              frame_abort,
   output logic [ADDR_W-1:0] addr
);
   localparam int RW       = $clog2(CMD_W + 1);
   localparam int LEN_RISE = CMD_W - 2;   // rising edge that completes the length field
   localparam int ORD_RISE = CMD_W - 1;   // rising edge carrying the order bit

   logic              in_frame;
   logic [RW-1:0]     rcnt;
   logic [KW-1:0]     fcnt, fnext, lim;
   logic [ADDR_W-2:0] addr_sh;
   logic              len_hi, ord_pend, fall_in;
   wlen_e             len_cur, len_prev;

   always_comb begin
      case (len_cur)
         LEN_LONG:  lim = KW'(LONG_W);
         LEN_SHORT: lim = KW'(SHORT_W);
         default:   lim = KW'(RES_W);
      endcase
   end

   assign fall_in     = fall & in_frame;
   assign fnext       = fcnt + 1'b1;
   assign frame_done  = fall_in && (fnext == lim);
   assign smp_begin   = fall_in && (fnext == KW'(ADDR_W));
   assign frame_abort = sel_end & in_frame;
   assign step        = sel_start | fall_in;
   assign step_idx    = sel_start ? '0 : fnext;
   assign step_len    = sel_start ? len_prev : len_cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_frame  <= 1'b0;
         rcnt      <= '0;
         fcnt      <= '0;
         addr_sh   <= '0;
         addr      <= '0;
         len_hi    <= 1'b0;
         ord_pend  <= 1'b0;
         order_lsb <= 1'b0;
         len_cur   <= LEN_MID;
         len_prev  <= LEN_MID;
      end else if (sel_start) begin
         in_frame <= 1'b1;
         rcnt     <= '0;
         fcnt     <= '0;
         len_cur  <= len_prev;
      end else begin
         if (rise && in_frame && (rcnt < RW'(CMD_W))) begin
            rcnt <= rcnt + 1'b1;
            if (rcnt < RW'(ADDR_W - 1))
               addr_sh <= {addr_sh[ADDR_W-3:0], din_s};
            if (rcnt == RW'(ADDR_W - 1))
               addr <= {addr_sh, din_s};
            if (rcnt == RW'(LEN_RISE - 2))
               len_hi <= din_s;
            if (rcnt == RW'(LEN_RISE - 1))
               len_cur <= decode_len({len_hi, din_s});
            if (rcnt == RW'(ORD_RISE - 1))
               ord_pend <= din_s;
         end
         if (fall_in) begin
            fcnt <= fnext;
            if (frame_done) begin
               in_frame  <= 1'b0;
               len_prev  <= len_cur;
               order_lsb <= ord_pend;
            end
         end
         if (frame_abort) in_frame <= 1'b0;
      end
   end

   // R1: no transfer counts past its own length
   p_fall_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
      in_frame |-> (fcnt < lim));

   // R9: once the length field is complete it holds for the rest of the transfer
   p_len_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (in_frame && rcnt >= RW'(LEN_RISE) && !sel_start) |=> $stable(len_cur));

   // R5: the output order moves only at the end of a transfer
   p_order_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_done |=> $stable(order_lsb));
endmodule

// File: rtl/sar_sport_tx.sv
module sar_sport_tx
   import sar_sport_pkg::*;
#(
   parameter int RES_W   = 12,
   parameter int SHORT_W = 8,
   parameter int LONG_W  = 16,
   parameter int KW      = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic [KW-1:0]    step_idx,
   input  wlen_e            step_len,
   input  logic             order_lsb,
   input  logic             conv_done,
   input  logic [RES_W-1:0] conv_val,
   output logic             dout
);
   localparam int PAD_W   = LONG_W - RES_W;
   localparam int TRUNC_W = RES_W - SHORT_W;

   logic [RES_W-1:0] result_q;
   logic             nxt_bit;

   function automatic logic pick(input logic [RES_W-1:0] r, input int idx,
                                 input wlen_e l, input logic lsb);
      int lim, off;
      logic [RES_W-1:0] sh;
      lim = (l == LEN_LONG) ? LONG_W : (l == LEN_SHORT) ? SHORT_W : RES_W;
      if (idx >= lim) return 1'b0;
      if (!lsb) off = RES_W - 1 - idx;
      else begin
         case (l)
            LEN_LONG:  off = idx - PAD_W;
            LEN_SHORT: off = idx + TRUNC_W;
            default:   off = idx;
         endcase
      end
      if (off < 0 || off >= RES_W) return 1'b0;
      sh = r >> off;
      return sh[0];
   endfunction

   assign nxt_bit = pick(result_q, int'(step_idx), step_len, order_lsb);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         result_q <= '0;
         dout     <= 1'b0;
      end else begin
         if (conv_done) result_q <= conv_val;
         if (step)      dout     <= nxt_bit;
      end
   end

   // R8: the held result changes only when a conversion completes
   p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !conv_done |=> $stable(result_q));

   // R2: the serial output moves only at chip-select or a falling I/O edge
   p_dout_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(dout));
endmodule

// File: rtl/sar_conv_stub.sv
module sar_conv_stub #(
   parameter int RES_W       = 12,
   parameter int ADDR_W      = 4,
   parameter int CONV_CYCLES = 40,
   parameter int STUB_MUL    = 273,
   parameter int STUB_ADD    = 245
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] addr,
   output logic              busy,
   output logic              done,
   output logic [RES_W-1:0]  value
);
   localparam int CW = $clog2(CONV_CYCLES + 1);

   logic [CW-1:0]     cnt;
   logic [ADDR_W-1:0] addr_q;

   generate
      if (CONV_CYCLES < 1) begin : g_bad_conv
         $error("CONV_CYCLES must be at least 1");
      end
   endgenerate

   assign done  = busy && (cnt == '0);
   assign value = RES_W'(32'(addr_q) * 32'(STUB_MUL) + 32'(STUB_ADD));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         cnt    <= '0;
         addr_q <= '0;
      end else if (start) begin
         busy   <= 1'b1;
         cnt    <= CW'(CONV_CYCLES - 1);
         addr_q <= addr;
      end else if (busy) begin
         if (cnt == '0) busy <= 1'b0;
         else           cnt  <= cnt - 1'b1;
      end
   end

   // R7: the countdown only runs downward while busy
   p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && cnt != '0 && !start) |=> (busy && cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/sar_serial_port.sv
module sar_serial_port
   import sar_sport_pkg::*;
#(
   parameter int RES_W       = 12,
   parameter int SHORT_W     = 8,
   parameter int LONG_W      = 16,
   parameter int CMD_W       = 8,
   parameter int ADDR_W      = 4,
   parameter int SYNC_STAGES = 2,
   parameter int CONV_CYCLES = 40,
   parameter int STUB_MUL    = 273,
   parameter int STUB_ADD    = 245
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_clk,
   input  logic              cs_n,
   input  logic              din,
   output logic              dout,
   output logic              eoc,
   output logic              sample,
   output logic              convert,
   output logic [ADDR_W-1:0] chan
);
   localparam int KW = $clog2(LONG_W + 1);

   generate
      if (CMD_W != 8) begin : g_bad_cmd
         $error("command word must be 8 bits");
      end
      if (ADDR_W < 2 || ADDR_W > CMD_W - 4) begin : g_bad_addr
         $error("ADDR_W out of range");
      end
      if (!(SHORT_W < RES_W && RES_W < LONG_W)) begin : g_bad_len
         $error("lengths must satisfy SHORT_W < RES_W < LONG_W");
      end
      if (SHORT_W < CMD_W) begin : g_bad_short
         $error("shortest transfer must hold the command");
      end
   endgenerate

   logic          rise, fall, sel_start, sel_end, din_s;
   logic          step, order_lsb, smp_begin, frame_done, frame_abort;
   logic [KW-1:0] step_idx;
   wlen_e         step_len;
   logic          conv_done;
   logic [RES_W-1:0] conv_val;
   logic          sample_q, eoc_q;

   sar_sport_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .io_clk(io_clk), .cs_n(cs_n), .din(din),
      .rise(rise), .fall(fall), .sel_start(sel_start), .sel_end(sel_end),
      .din_s(din_s));

   sar_sport_frame #(
      .RES_W(RES_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W),
      .CMD_W(CMD_W), .ADDR_W(ADDR_W), .KW(KW)
   ) u_frame (
      .clk(clk), .rst_n(rst_n), .rise(rise), .fall(fall),
      .sel_start(sel_start), .sel_end(sel_end), .din_s(din_s),
      .step(step), .step_idx(step_idx), .step_len(step_len),
      .order_lsb(order_lsb), .smp_begin(smp_begin), .frame_done(frame_done),
      .frame_abort(frame_abort), .addr(chan));

   sar_sport_tx #(
      .RES_W(RES_W), .SHORT_W(SHORT_W), .LONG_W(LONG_W), .KW(KW)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .step(step), .step_idx(step_idx),
      .step_len(step_len), .order_lsb(order_lsb), .conv_done(conv_done),
      .conv_val(conv_val), .dout(dout));

   sar_conv_stub #(
      .RES_W(RES_W), .ADDR_W(ADDR_W), .CONV_CYCLES(CONV_CYCLES),
      .STUB_MUL(STUB_MUL), .STUB_ADD(STUB_ADD)
   ) u_stub (
      .clk(clk), .rst_n(rst_n), .start(frame_done), .addr(chan),
      .busy(convert), .done(conv_done), .value(conv_val));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sample_q <= 1'b0;
         eoc_q    <= 1'b1;
      end else begin
         if (frame_done || frame_abort) sample_q <= 1'b0;
         else if (smp_begin)            sample_q <= 1'b1;
         if (frame_done)     eoc_q <= 1'b0;
         else if (conv_done) eoc_q <= 1'b1;
      end
   end

   assign sample = sample_q;
   assign eoc    = eoc_q;

   // R6: sampling and converting never overlap
   p_phase_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !(sample && convert));

   // R1: a conversion begins exactly where the sample window closes
   p_conv_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(convert) |-> $fell(sample));

   // R7: end-of-conversion is low for the whole conversion
   p_eoc_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      convert |-> !eoc);
endmodule

// File: tb/sar_serial_port_tb.sv
`timescale 1ns/1ps
module sar_serial_port_tb;
   localparam int CONV = 40;
   localparam int HALF = 6;
   localparam int NV   = 11;

   // command per transfer; comment names the requirement the word check targets
   localparam logic [7:0] VEC [NV] = '{
      8'h10,   // R10 reset result comes out first
      8'h2C,   // R3  16-clock MSB-first pad
      8'h34,   // R4  8-clock MSB-first truncation
      8'h42,   // R2  order bit set, still MSB first
      8'h5A,   // R5  now LSB first
      8'h6E,   // R9  12 -> 16 in LSB-first order
      8'h7E,   // R3  16-clock LSB-first pad
      8'h86,   // R9  16 -> 8 in LSB-first order
      8'h94,   // R4  8-clock LSB-first
      8'hA0,   // R5  back to MSB first
      8'hF8    // R8  result pipeline
   };

   logic clk = 1'b0, rst_n = 1'b0, io_clk = 1'b0, cs_n = 1'b1, din = 1'b0;
   logic dout, eoc, sample, convert;
   logic [3:0] chan;
   int n_chk = 0, n_bad = 0;

   logic [11:0] m_res = '0;
   bit          m_lsb = 1'b0;
   int          m_len = 12;
   string       tags [NV] = '{"R10","R3","R4","R2","R5","R9","R3","R9","R4","R5","R8"};

   always #4 clk = ~clk;

   sar_serial_port u_dut (
      .clk(clk), .rst_n(rst_n), .io_clk(io_clk), .cs_n(cs_n), .din(din),
      .dout(dout), .eoc(eoc), .sample(sample), .convert(convert), .chan(chan));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic int len_of(input logic [1:0] f);
      return (f == 2'b01) ? 8 : (f == 2'b11) ? 16 : 12;
   endfunction

   function automatic logic [11:0] stub(input logic [3:0] a);
      return 12'((int'(a) * 273 + 245) % 4096);
   endfunction

   // word of length L as sent MSB first
   function automatic logic exp_bit(input logic [11:0] r, input int k,
                                    input int L, input bit lsb);
      logic [15:0] w;
      w = (L == 16) ? {r, 4'h0} : (L == 8) ? {8'h00, r[11:4]} : {4'h0, r};
      if (k >= L) return 1'b0;
      return lsb ? w[k] : w[L-1-k];
   endfunction

   task automatic run_frame(input logic [7:0] cmd, input string tag);
      int L;
      logic [15:0] got, exp;
      logic s3, s4, e_pre, c_pre;
      L = len_of(cmd[3:2]);
      got = '0; exp = '0;
      for (int k = 0; k < L; k++)
         exp[k] = exp_bit(m_res, k, (k < 6) ? m_len : L, m_lsb);
      cs_n = 1'b0;
      for (int i = 0; i < L; i++) begin
         din = (i < 8) ? cmd[7-i] : 1'b0;
         tick(HALF);
         got[i] = dout;
         if (i == 3) s3 = sample;
         if (i == 4) s4 = sample;
         if (i == L - 1) begin e_pre = eoc; c_pre = convert; end
         io_clk = 1'b1;
         tick(HALF);
         io_clk = 1'b0;
      end
      tick(HALF);
      chk(got == exp, tag, "serial word", got, exp);
      chk(s3 == 1'b0 && s4 == 1'b1, "R6", "sample window opens at 4th fall",
          {14'd0, s3, s4}, 16'h0001);
      chk(e_pre && !c_pre && !eoc && convert && !sample, "R1",
          "conversion starts at last fall",
          {11'd0, e_pre, c_pre, eoc, convert, sample}, 16'h0012);
      chk(chan == cmd[7:4], "R8", "channel address", {12'd0, chan}, {12'd0, cmd[7:4]});
      cs_n = 1'b1;
      tick(HALF + CONV + 8);
      chk(eoc && !convert, "R7", "conversion completes", {14'd0, eoc, convert}, 16'h0002);
      m_res = stub(cmd[7:4]);
      m_len = L;
      m_lsb = cmd[1];
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      tick(5);
      // R10: reset state
      chk(dout == 0 && eoc == 1 && sample == 0 && convert == 0 && chan == 0, "R10",
          "reset outputs", {11'd0, dout, eoc, sample, convert, 1'b0}, 16'h0008);
      rst_n = 1'b1;
      tick(10);
      chk(dout == 0 && eoc == 1, "R10", "idle after reset", {14'd0, dout, eoc}, 16'h0001);

      for (int v = 0; v < NV; v++) run_frame(VEC[v], tags[v]);

      // R11: abort after five bits; no conversion, settings kept
      cs_n = 1'b0;
      for (int i = 0; i < 5; i++) begin
         din = ~din;
         tick(HALF);
         io_clk = 1'b1;
         tick(HALF);
         io_clk = 1'b0;
      end
      tick(HALF);
      cs_n = 1'b1;
      tick(3);
      chk(eoc && !convert && !sample, "R11", "abort starts nothing",
          {13'd0, eoc, convert, sample}, 16'h0004);
      tick(CONV + 8);
      chk(eoc && !convert, "R11", "still idle after abort", {14'd0, eoc, convert}, 16'h0002);
      run_frame(8'hB0, "R11");
      run_frame(8'hC1, "R2");

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule